// File: doc/BRIEF.md
# INT8 Tile Matrix-Multiply-Accumulate Engine

The engine multiplies signed 8-bit matrices in 4x4 output blocks and keeps the results in sixteen 32-bit accumulators. Each accepted operand beat carries one K slice: four rows of A (four INT8 values each) and four columns of B (four INT8 values each). Every beat adds sixteen four-element dot products into the accumulator block. The datapath has a fixed depth of four registered stages: operand capture, multiplication, carry-save reduction, and a parallel-prefix add into the accumulators. A new slice can enter on every cycle.

A sequencer walks a full tile, by default 16x16x16. For each of the (M/4)x(N/4) output blocks it takes K/4 slices, then streams the finished 4x4 block out in row-major order. Operand intake is blocked from the moment the last slice of a block is accepted until that block has been read out. After the final block has been read out, a done flag rises and stays high until a start pulse re-arms the engine. Software can also restart accumulation within a block by flagging a slice as clearing.

Top module: `mma4_tile_engine`

## Requirements
- R1: Operand bytes are signed two's complement and are sign-extended before multiplication. Byte k (bits 8k+7..8k) of word r of `op_a` is A[r][k]. Byte k of word c of `op_b` is B[k][c]. Word i occupies bits 32i+31..32i. The extreme values -128 and 127 produce exact products.
- R2: After all K/4 slices of a block, accumulator (r,c) holds the sum over every k of A[r][k]*B[k][c].
- R3: The first slice of every block loads the accumulators instead of adding to them, so no value carries over from the previous block.
- R4: A slice accepted with `op_clear`=1 loads its products into the accumulators and discards the earlier slices of the block.
- R5: `op_ready` stays high while the slices of a block are streamed back to back. It is low from the clock edge that accepts a block's final slice until the edge that accepts that block's last readout beat.
- R6: `rd_valid` rises on the fourth clock edge after the edge that accepted a block's final slice.
- R7: A block is read out as 16 beats in row-major order (index r*4+c). `rd_last` is high on the 16th beat only, and `rd_valid` falls after that beat is accepted.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold their values.
- R9: `done` rises when the last beat of the final block of a tile is accepted. It keeps `op_ready` low and stays high until `start` is pulsed, which clears it and restarts the block and slice count.
- R10: After reset `op_ready` is 1, `rd_valid` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: clear done, restart tile count |
| op_valid | input | 1 | Operand slice valid |
| op_ready | output | 1 | Engine accepts a slice |
| op_clear | input | 1 | This slice loads instead of accumulating |
| op_a | input | 128 | Four packed A rows, four INT8 each |
| op_b | input | 128 | Four packed B columns, four INT8 each |
| rd_valid | output | 1 | Readout beat valid |
| rd_ready | input | 1 | Readout beat accepted |
| rd_data | output | 32 | Accumulator value, row-major |
| rd_last | output | 1 | Final beat of a block |
| done | output | 1 | Whole tile read out |

## Verification
Two situations are the hardest to reach from the ports: a clearing slice in the middle of a block, and a readout stall that overlaps a beat boundary. The bench sweeps three complete 16x16x16 tiles and computes every expected accumulator arithmetically. In the third tile, selected blocks raise the clear flag on their third or fourth slice. Every other block holds `rd_ready` low on a repeating beat pattern, so the held data and the `rd_last` position are observed under backpressure. The second tile uses only -128 and 127 to exercise the signed extremes.

// File: rtl/mma_pkg.sv
package mma_pkg;
  localparam int EW    = 8;          // operand element width
  localparam int PW    = 2 * EW;     // product width
  localparam int AW    = 32;         // accumulator width
  localparam int GRID  = 4;          // block edge and slice depth
  localparam int WORDW = GRID * EW;  // packed operand word
endpackage

// File: rtl/mma_ks_adder.sv
module mma_ks_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  localparam int LV = $clog2(W);

  logic [W-1:0] g;
  logic [W-1:0] p;

  // Kogge-Stone prefix: descending index keeps each level reading old values
  always_comb begin
    g = a & b;
    p = a ^ b;
    for (int lv = 0; lv < LV; lv++) begin
      for (int i = W - 1; i >= 0; i--) begin
        if (i >= (1 << lv)) begin
          g[i] = g[i] | (p[i] & g[i - (1 << lv)]);
          p[i] = p[i] & p[i - (1 << lv)];
        end
      end
    end
  end

  assign s = (a ^ b) ^ {g[W-2:0], 1'b0};
endmodule

// File: rtl/mma_dot_lane.sv
module mma_dot_lane
  import mma_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v_in,
  input  logic                    clr_in,
  input  logic [WORDW-1:0]        a_word,
  input  logic [GRID*WORDW-1:0]   b_words,
  output logic [GRID*AW-1:0]      acc_o
);
  // stage 2: multipliers
  logic signed [PW-1:0] prod_q [GRID][GRID];
  logic v2_q, clr2_q;

  always_ff @(posedge clk) begin
    for (int c = 0; c < GRID; c++) begin
      for (int k = 0; k < GRID; k++) begin
        prod_q[c][k] <= PW'(signed'(a_word[EW*k +: EW]))
                      * PW'(signed'(b_words[WORDW*c + EW*k +: EW]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2_q   <= 1'b0;
      clr2_q <= 1'b0;
    end else begin
      v2_q   <= v_in;
      clr2_q <= clr_in;
    end
  end

  // stage 3: two 3:2 compressor rows per output
  logic [AW-1:0] sum_d [GRID];
  logic [AW-1:0] car_d [GRID];
  logic [AW-1:0] sum_q [GRID];
  logic [AW-1:0] car_q [GRID];
  logic v3_q, clr3_q;

  always_comb begin
    for (int c = 0; c < GRID; c++) begin
      logic [AW-1:0] x0, x1, x2, x3, s1, c1;
      x0 = AW'(prod_q[c][0]);
      x1 = AW'(prod_q[c][1]);
      x2 = AW'(prod_q[c][2]);
      x3 = AW'(prod_q[c][3]);
      s1 = x0 ^ x1 ^ x2;
      c1 = ((x0 & x1) | (x0 & x2) | (x1 & x2)) << 1;
      sum_d[c] = s1 ^ c1 ^ x3;
      car_d[c] = ((s1 & c1) | (s1 & x3) | (c1 & x3)) << 1;
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < GRID; c++) begin
      sum_q[c] <= sum_d[c];
      car_q[c] <= car_d[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v3_q   <= 1'b0;
      clr3_q <= 1'b0;
    end else begin
      v3_q   <= v2_q;
      clr3_q <= clr2_q;
    end
  end

  // stage 4: merge accumulator, carry-save pair, prefix add
  logic [AW-1:0] acc_q [GRID];
  logic [AW-1:0] t_d   [GRID];
  logic [AW-1:0] u_d   [GRID];
  logic [AW-1:0] nxt_d [GRID];

  always_comb begin
    for (int c = 0; c < GRID; c++) begin
      logic [AW-1:0] base;
      base   = clr3_q ? '0 : acc_q[c];
      t_d[c] = base ^ sum_q[c] ^ car_q[c];
      u_d[c] = ((base & sum_q[c]) | (base & car_q[c]) | (sum_q[c] & car_q[c])) << 1;
    end
  end

  for (genvar c = 0; c < GRID; c++) begin : g_col
    mma_ks_adder #(.W(AW)) i_ks (
      .a (t_d[c]),
      .b (u_d[c]),
      .s (nxt_d[c])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[c] <= '0;
      end else if (v3_q) begin
        acc_q[c] <= nxt_d[c];
      end
    end

    assign acc_o[AW*c +: AW] = acc_q[c];
  end
endmodule

// File: rtl/mma_seq_ctrl.sv
module mma_seq_ctrl
  import mma_pkg::*;
#(
  parameter int SLICES = 4,
  parameter int BLOCKS = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     op_valid,
  input  logic                     op_clear,
  output logic                     op_ready,
  output logic                     issue_fire,
  output logic                     issue_clr,
  input  logic [GRID*GRID*AW-1:0]  acc_all,
  input  logic                     rd_ready,
  output logic                     rd_valid,
  output logic [AW-1:0]            rd_data,
  output logic                     rd_last,
  output logic                     done
);
  localparam int SW    = (SLICES > 1) ? $clog2(SLICES) : 1;
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
  localparam int NOUT  = GRID * GRID;
  localparam int RW    = $clog2(NOUT);
  localparam int DEPTH = 3;

  logic [SW-1:0]    slice_q;
  logic [BW-1:0]    blk_q;
  logic             lock_q, done_q;
  logic [DEPTH-1:0] lp_q;
  logic             rd_start_q, rd_valid_q;
  logic [RW-1:0]    rd_pos_q;
  logic [AW-1:0]    rd_data_q;

  logic          is_last, rd_fire, rd_end;
  logic [RW-1:0] nxt_pos;

  assign op_ready   = !lock_q && !done_q;
  assign issue_fire = op_valid && op_ready;
  assign issue_clr  = (slice_q == '0) || op_clear;
  assign is_last    = (slice_q == SW'(SLICES - 1));
  assign rd_fire    = rd_valid_q && rd_ready;
  assign rd_end     = rd_fire && (rd_pos_q == RW'(NOUT - 1));
  assign nxt_pos    = rd_pos_q + RW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slice_q    <= '0;
      blk_q      <= '0;
      lock_q     <= 1'b0;
      done_q     <= 1'b0;
      lp_q       <= '0;
      rd_start_q <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_pos_q   <= '0;
      rd_data_q  <= '0;
    end else begin
      lp_q       <= {lp_q[DEPTH-2:0], issue_fire && is_last};
      rd_start_q <= lp_q[DEPTH-1];

      if (issue_fire && is_last) lock_q <= 1'b1;
      else if (rd_end)           lock_q <= 1'b0;

      if (start) begin
        slice_q <= '0;
        blk_q   <= '0;
        done_q  <= 1'b0;
      end else begin
        if (issue_fire) slice_q <= is_last ? '0 : slice_q + SW'(1);
        if (rd_end) begin
          if (blk_q == BW'(BLOCKS - 1)) begin
            blk_q  <= '0;
            done_q <= 1'b1;
          end else begin
            blk_q <= blk_q + BW'(1);
          end
        end
      end

      if (rd_start_q) begin
        rd_valid_q <= 1'b1;
        rd_pos_q   <= '0;
        rd_data_q  <= acc_all[AW-1:0];
      end else if (rd_fire) begin
        if (rd_pos_q == RW'(NOUT - 1)) begin
          rd_valid_q <= 1'b0;
        end else begin
          rd_pos_q  <= nxt_pos;
          rd_data_q <= acc_all[AW*nxt_pos +: AW];
        end
      end
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign rd_last  = rd_valid_q && (rd_pos_q == RW'(NOUT - 1));
  assign done     = done_q;

  AST_READY_LOCKED: assert property (@(posedge clk) disable iff (rst)
    rd_valid_q |-> !op_ready); // R5

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_valid_q && !rd_ready |=> rd_valid_q && $stable(rd_data_q)); // R8

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid_q) |-> $past(issue_fire && is_last, 5)); // R6

  AST_BLOCK_END: assert property (@(posedge clk) disable iff (rst)
    rd_last && rd_ready |=> !rd_valid_q); // R7

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(rd_last && rd_ready)); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done_q && !start |=> done_q); // R9
endmodule

// File: rtl/mma4_tile_engine.sv
module mma4_tile_engine
  import mma_pkg::*;
#(
  parameter int TILE_M = 16,
  parameter int TILE_N = 16,
  parameter int TILE_K = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   op_valid,
  output logic                   op_ready,
  input  logic                   op_clear,
  input  logic [GRID*WORDW-1:0]  op_a,
  input  logic [GRID*WORDW-1:0]  op_b,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [AW-1:0]          rd_data,
  output logic                   rd_last,
  output logic                   done
);
  localparam int SLICES = TILE_K / GRID;
  localparam int BLOCKS = (TILE_M / GRID) * (TILE_N / GRID);

  logic                    issue_fire, issue_clr;
  logic                    v1_q, clr1_q;
  logic [GRID*WORDW-1:0]   a_q, b_q;
  logic [GRID*GRID*AW-1:0] acc_all;

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q   <= 1'b0;
      clr1_q <= 1'b0;
    end else begin
      v1_q   <= issue_fire;
      clr1_q <= issue_clr;
    end
  end

  always_ff @(posedge clk) begin
    if (issue_fire) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  for (genvar r = 0; r < GRID; r++) begin : g_lane
    mma_dot_lane i_lane (
      .clk     (clk),
      .rst     (rst),
      .v_in    (v1_q),
      .clr_in  (clr1_q),
      .a_word  (a_q[WORDW*r +: WORDW]),
      .b_words (b_q),
      .acc_o   (acc_all[GRID*AW*r +: GRID*AW])
    );
  end

  mma_seq_ctrl #(
    .SLICES (SLICES),
    .BLOCKS (BLOCKS)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op_valid   (op_valid),
    .op_clear   (op_clear),
    .op_ready   (op_ready),
    .issue_fire (issue_fire),
    .issue_clr  (issue_clr),
    .acc_all    (acc_all),
    .rd_ready   (rd_ready),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_last    (rd_last),
    .done       (done)
  );
endmodule

// File: tb/test_mma4_tile_engine.sv
module test_mma4_tile_engine;
  logic         clk = 1'b0;
  logic         rst, start, op_valid, op_clear, rd_ready;
  logic [127:0] op_a, op_b;
  logic         op_ready, rd_valid, rd_last, done;
  logic [31:0]  rd_data;

  always #2 clk = ~clk;

  mma4_tile_engine i_mma4_tile_engine (
    .clk(clk), .rst(rst), .start(start),
    .op_valid(op_valid), .op_ready(op_ready), .op_clear(op_clear),
    .op_a(op_a), .op_b(op_b),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 0;
  int A [16][16];
  int B [16][16];
  logic [31:0] expv [16];
  int unsigned seed;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expd, string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expd);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hff) - 128;
  endfunction

  task automatic run_block(int br, int bc, int clr_s, bit stall, string req);
    int s0;
    int n;
    logic [31:0] hold;
    s0 = (clr_s > 0) ? clr_s : 0;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        int acc;
        acc = 0;
        for (int k = s0 * 4; k < 16; k++) acc += A[br*4+r][k] * B[k][bc*4+c];
        expv[r*4+c] = acc;
      end
    end
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      chk(op_ready == 1'b1, "R5", 32'(op_ready), 32'd1, "ready during slices");
      op_valid = 1'b1;
      op_clear = (s == clr_s);
      for (int i = 0; i < 4; i++) begin
        for (int kk = 0; kk < 4; kk++) begin
          op_a[32*i + 8*kk +: 8] = 8'(A[br*4+i][s*4+kk]);
          op_b[32*i + 8*kk +: 8] = 8'(B[s*4+kk][bc*4+i]);
        end
      end
    end
    @(negedge clk);
    op_valid = 1'b0;
    op_clear = 1'b0;
    chk(op_ready == 1'b0, "R5", 32'(op_ready), 32'd0, "ready after final slice");
    n = 0;
    while (!rd_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == 4, "R6", 32'(n), 32'd4, "readout latency");
    for (int b = 0; b < 16; b++) begin
      if (stall && (b % 3 == 1)) begin
        rd_ready = 1'b0;
        hold = rd_data;
        @(negedge clk);
        chk(rd_valid && rd_data == hold, "R8", rd_data, hold, "stalled beat");
      end
      rd_ready = 1'b1;
      chk(rd_data == expv[b], req, rd_data, expv[b], "accumulator");
      chk(rd_last == (b == 15), "R7", 32'(rd_last), 32'(b == 15), "last marker");
      @(negedge clk);
    end
    rd_ready = 1'b0;
    chk(rd_valid == 1'b0, "R7", 32'(rd_valid), 32'd0, "valid after block");
  endtask

  task automatic run_tile(int t);
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        if (t == 1) begin
          A[i][j] = ((i + j) % 2 == 1) ? 127 : -128;
          B[i][j] = (i % 3 == 0) ? 127 : -128;
        end else begin
          A[i][j] = rnd8();
          B[i][j] = rnd8();
        end
      end
    end
    for (int blk = 0; blk < 16; blk++) begin
      int cs;
      string rq;
      cs = -1;
      rq = (t == 0) ? "R2" : ((t == 1) ? "R1" : "R3");
      if (t == 2 && blk % 3 == 1) cs = 2;
      if (t == 2 && blk % 3 == 2) cs = 3;
      if (cs >= 0) rq = "R4";
      run_block(blk / 4, blk % 4, cs, (blk % 2) == 0, rq);
    end
    chk(done == 1'b1, "R9", 32'(done), 32'd1, "done after tile");
    chk(op_ready == 1'b0, "R9", 32'(op_ready), 32'd0, "ready while done");
    @(negedge clk);
    chk(done == 1'b1, "R9", 32'(done), 32'd1, "done holds");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R9", 32'(done), 32'd0, "done cleared by start");
    chk(op_ready == 1'b1, "R9", 32'(op_ready), 32'd1, "ready after start");
  endtask

  initial begin
    seed = 32'd7;
    rst = 1'b1; start = 1'b0; op_valid = 1'b0; op_clear = 1'b0;
    rd_ready = 1'b0; op_a = '0; op_b = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(op_ready == 1'b1, "R10", 32'(op_ready), 32'd1, "reset ready");
    chk(rd_valid == 1'b0, "R10", 32'(rd_valid), 32'd0, "reset valid");
    chk(done == 1'b0, "R10", 32'(done), 32'd0, "reset done");
    for (int t = 0; t < 3; t++) run_tile(t);
    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected tile completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule